// File: doc/BRIEF.md
# Page-Fault Handoff Controller for Two Non-Restartable CPUs

This block is bus glue for a system with two processors that cannot restart a faulted instruction, but where demand paging is still wanted. The primary CPU runs user code. Every primary access is checked against a page-valid input that an external page table supplies. A resident page completes normally with a data acknowledge. When the page is not resident, the primary gets no acknowledge and no bus error. Its cycle is simply held open, so it sits in a wait state, and the secondary CPU is woken by an interrupt.

The secondary reads the faulting address from a register and writes a retry command. The controller then asserts halt, bus-error and bus-request to the primary together. The primary takes this as a relinquish-and-retry: it ends its cycle and answers with a grant acknowledge. The secondary then owns the bus and loads the page. Next it writes a page-fixed command, which corresponds to its return-from-exception followed by a stop. Ownership goes back to the primary after one idle cycle, and the primary reruns the held cycle with the same address.

Top module: `pf_handoff_ctrl`

## Requirements
- R1: In reset and in the cycle after it, `grant_pri` is 1, and `grant_sec`, `s_irq`, `p_dtack`, `p_halt`, `p_berr` and `p_br` are all 0.
- R2: When the primary owns the bus in normal run, `p_req` together with `pg_valid`=1 raises `p_dtack` at the next clock edge. `p_dtack` falls at the edge after `p_req` drops.
- R3: A primary access with `pg_valid`=0 during normal run raises `s_irq` at the next edge and never raises `p_dtack`. The primary is held without an acknowledge for as long as the fault is pending.
- R4: A secondary write with command bit 0 (retry) set while the fault is pending raises `p_halt`, `p_berr` and `p_br` together at the next edge, and clears `s_irq` at that same edge.
- R5: Halt and bus-error stay asserted until `p_bgack` is seen. At the edge after `p_bgack`, both fall together, `p_br` stays high, `grant_sec` rises and `grant_pri` falls.
- R6: A secondary write with command bit 1 (page fixed) while the secondary owns the bus drops `p_br` and `grant_sec` at the next edge. No CPU holds a grant for that one cycle, and `grant_pri` returns at the edge after it.
- R7: `grant_pri` and `grant_sec` are never both 1.
- R8: A command bit written outside the state it belongs to has no effect. If both bits are written while a fault is pending, only the retry is taken.
- R9: `s_rdata` shows the address of the last faulted access. It stays unchanged until the next fault. After ownership returns, the primary's rerun of that address is acknowledged once the page is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_req | input | 1 | Primary access strobe, held until acknowledged |
| p_addr | input | AW | Primary access address |
| pg_valid | input | 1 | Page-table lookup result for p_addr, 1 = resident |
| p_bgack | input | 1 | Primary has ended its cycle and released the bus |
| s_wr | input | 1 | Secondary command-register write strobe |
| s_wdata | input | 2 | Command bits: bit 0 retry, bit 1 page fixed |
| p_dtack | output | 1 | Data acknowledge to the primary |
| p_halt | output | 1 | Halt to the primary |
| p_berr | output | 1 | Bus error to the primary (only as part of a retry) |
| p_br | output | 1 | Bus request to the primary |
| grant_pri | output | 1 | Primary owns the bus |
| grant_sec | output | 1 | Secondary owns the bus |
| s_irq | output | 1 | Page-fault interrupt to the secondary |
| s_rdata | output | AW | Faulting address register, readable by the secondary |

## Verification
Two events can fall in the same clock cycle here. The first is the primary's grant acknowledge arriving in the same cycle as a page-fixed write from the secondary. The second is a retry and a page-fixed command written in one word while a fault is pending. Both are forced deliberately at fixed addresses during a sweep over every address in a small configuration. The result is judged at the ports: the secondary must still own the bus one cycle later, and the controller must sit in the retry assertion and not in the give-back state.

// File: rtl/pf_handoff_pkg.sv
package pf_handoff_pkg;
  typedef enum logic [2:0] {
    ST_PRI_RUN    = 3'd0,
    ST_FAULT_HOLD = 3'd1,
    ST_RETRY      = 3'd2,
    ST_SEC_OWN    = 3'd3,
    ST_GIVE_BACK  = 3'd4
  } hs_state_e;

  localparam int CMD_W         = 2;
  localparam int CMD_RETRY_BIT = 0;
  localparam int CMD_FIXED_BIT = 1;
endpackage

// File: rtl/pf_handoff_fsm.sv
module pf_handoff_fsm
  import pf_handoff_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             p_req,
  input  logic             pg_valid,
  input  logic             p_bgack,
  input  logic             s_wr,
  input  logic [CMD_W-1:0] s_wdata,
  output hs_state_e        state,
  output logic             miss_take
);
  hs_state_e state_q, state_d;
  logic      cmd_retry, cmd_fixed;

  assign cmd_retry = s_wr & s_wdata[CMD_RETRY_BIT];
  assign cmd_fixed = s_wr & s_wdata[CMD_FIXED_BIT];
  assign miss_take = (state_q == ST_PRI_RUN) & p_req & ~pg_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PRI_RUN:    if (miss_take) state_d = ST_FAULT_HOLD;
      ST_FAULT_HOLD: if (cmd_retry) state_d = ST_RETRY;
      ST_RETRY:      if (p_bgack)   state_d = ST_SEC_OWN;
      ST_SEC_OWN:    if (cmd_fixed) state_d = ST_GIVE_BACK;
      ST_GIVE_BACK:                 state_d = ST_PRI_RUN;
      default:                      state_d = ST_PRI_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PRI_RUN;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/pf_fault_latch.sv
module pf_fault_latch #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  logic [AW-1:0] addr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_r <= '0;
    else if (cap_en) addr_r <= addr_in;
  end

  assign addr_q = addr_r;
endmodule

// File: rtl/pf_ack_gen.sv
module pf_ack_gen
  import pf_handoff_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hs_state_e state,
  input  logic      p_req,
  input  logic      pg_valid,
  output logic      dtack
);
  logic ack_d, ack_q;

  assign ack_d = (state == ST_PRI_RUN) & p_req & pg_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign dtack = ack_q;
endmodule

// File: rtl/pf_handoff_ctrl.sv
module pf_handoff_ctrl
  import pf_handoff_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             p_req,
  input  logic [AW-1:0]    p_addr,
  input  logic             pg_valid,
  input  logic             p_bgack,
  input  logic             s_wr,
  input  logic [CMD_W-1:0] s_wdata,
  output logic             p_dtack,
  output logic             p_halt,
  output logic             p_berr,
  output logic             p_br,
  output logic             grant_pri,
  output logic             grant_sec,
  output logic             s_irq,
  output logic [AW-1:0]    s_rdata
);
  hs_state_e state;
  logic      miss_take;

  pf_handoff_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .p_req     (p_req),
    .pg_valid  (pg_valid),
    .p_bgack   (p_bgack),
    .s_wr      (s_wr),
    .s_wdata   (s_wdata),
    .state     (state),
    .miss_take (miss_take)
  );

  pf_fault_latch #(.AW(AW)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (miss_take),
    .addr_in (p_addr),
    .addr_q  (s_rdata)
  );

  pf_ack_gen u_ack (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .p_req    (p_req),
    .pg_valid (pg_valid),
    .dtack    (p_dtack)
  );

  always_comb begin
    p_halt    = (state == ST_RETRY);
    p_berr    = (state == ST_RETRY);
    p_br      = (state == ST_RETRY) | (state == ST_SEC_OWN);
    s_irq     = (state == ST_FAULT_HOLD);
    grant_sec = (state == ST_SEC_OWN);
    grant_pri = (state == ST_PRI_RUN) | (state == ST_FAULT_HOLD) | (state == ST_RETRY);
  end
endmodule

// File: rtl/pf_handoff_chk.sv
module pf_handoff_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          p_req,
  input logic          pg_valid,
  input logic          p_dtack,
  input logic          p_halt,
  input logic          p_berr,
  input logic          p_br,
  input logic          grant_pri,
  input logic          grant_sec,
  input logic          s_irq,
  input logic [AW-1:0] s_rdata
);
  p_grant_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_pri && grant_sec));

  p_no_ack_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_irq |-> !p_dtack);

  p_miss_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_pri && !s_irq && !p_halt && p_req && !pg_valid) |=> s_irq);

  p_retry_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_halt) |-> (p_berr && p_br && !s_irq));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(p_halt) |-> (!p_berr && p_br && grant_sec && !grant_pri));

  p_give_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(p_br) |-> (!grant_pri && !grant_sec));

  p_give_back_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(p_br) |=> grant_pri);

  p_fault_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_irq && $past(s_irq)) |-> $stable(s_rdata));
endmodule

bind pf_handoff_ctrl pf_handoff_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .p_req     (p_req),
  .pg_valid  (pg_valid),
  .p_dtack   (p_dtack),
  .p_halt    (p_halt),
  .p_berr    (p_berr),
  .p_br      (p_br),
  .grant_pri (grant_pri),
  .grant_sec (grant_sec),
  .s_irq     (s_irq),
  .s_rdata   (s_rdata)
);

// File: tb/tb_pf_handoff_ctrl.sv
`timescale 1ns/1ps
module tb_pf_handoff_ctrl;
  localparam int AW = 6;
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          p_req, pg_valid, p_bgack, s_wr;
  logic [AW-1:0] p_addr;
  logic [1:0]    s_wdata;
  logic          p_dtack, p_halt, p_berr, p_br, grant_pri, grant_sec, s_irq;
  logic [AW-1:0] s_rdata;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  bit  resident [NA];

  always #4 clk = ~clk;

  pf_handoff_ctrl #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_addr(p_addr),
    .pg_valid(pg_valid), .p_bgack(p_bgack), .s_wr(s_wr), .s_wdata(s_wdata),
    .p_dtack(p_dtack), .p_halt(p_halt), .p_berr(p_berr), .p_br(p_br),
    .grant_pri(grant_pri), .grant_sec(grant_sec), .s_irq(s_irq),
    .s_rdata(s_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic excl();
    chk("R7", {31'd0, grant_pri & grant_sec}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; p_req = 1'b0; pg_valid = 1'b0; p_bgack = 1'b0;
    s_wr = 1'b0; s_wdata = 2'b00; p_addr = '0;
    for (int a = 0; a < NA; a++) resident[a] = (a % 3) != 0;
    repeat (3) @(negedge clk);
    chk("R1", {31'd0, grant_pri}, 32'd1);
    chk("R1", {26'd0, grant_sec, s_irq, p_dtack, p_halt, p_berr, p_br}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'd0, grant_pri}, 32'd1);
    chk("R1", {26'd0, grant_sec, s_irq, p_dtack, p_halt, p_berr, p_br}, 32'd0);

    // R8: both command bits written during normal run are ignored
    s_wr = 1'b1; s_wdata = 2'b11;
    @(negedge clk);
    s_wr = 1'b0;
    chk("R8", {29'd0, p_halt, p_br, grant_pri}, 32'd1);
    @(negedge clk);
    chk("R8", {30'd0, grant_sec, grant_pri}, 32'd1);

    for (int a = 0; a < NA; a++) begin
      p_addr = a[AW-1:0]; pg_valid = resident[a]; p_req = 1'b1;
      @(negedge clk);
      excl();
      if (resident[a]) begin
        chk("R2", {31'd0, p_dtack}, 32'd1);
        chk("R2", {31'd0, s_irq}, 32'd0);
        p_req = 1'b0;
        @(negedge clk);
        chk("R2", {31'd0, p_dtack}, 32'd0);
      end else begin
        chk("R3", {30'd0, s_irq, p_dtack}, 32'd2);
        chk("R9", {26'd0, s_rdata}, a);
        if (a == 0) begin
          s_wr = 1'b1; s_wdata = 2'b10;
          @(negedge clk);
          s_wr = 1'b0;
          chk("R8", {29'd0, s_irq, grant_sec, p_br}, 32'd4);
        end else begin
          @(negedge clk);
        end
        chk("R3", {31'd0, p_dtack}, 32'd0);
        s_wr = 1'b1; s_wdata = (a == 3) ? 2'b11 : 2'b01;
        @(negedge clk);
        s_wr = 1'b0;
        excl();
        chk("R4", {28'd0, p_halt, p_berr, p_br, s_irq}, 32'd14);
        if (a == 3) chk("R8", {30'd0, grant_sec, grant_pri}, 32'd1);
        @(negedge clk);
        chk("R5", {29'd0, p_halt, p_berr, p_br}, 32'd7);
        chk("R3", {31'd0, p_dtack}, 32'd0);
        p_req = 1'b0; p_bgack = 1'b1;
        if (a == 6) begin s_wr = 1'b1; s_wdata = 2'b10; end
        @(negedge clk);
        p_bgack = 1'b0; s_wr = 1'b0;
        excl();
        chk("R5", {27'd0, p_halt, p_berr, p_br, grant_sec, grant_pri}, 32'd6);
        if (a == 6) begin
          @(negedge clk);
          chk("R8", {30'd0, grant_sec, p_br}, 32'd3);
        end
        resident[a] = 1'b1;
        s_wr = 1'b1; s_wdata = 2'b10;
        @(negedge clk);
        s_wr = 1'b0;
        chk("R6", {29'd0, p_br, grant_sec, grant_pri}, 32'd0);
        @(negedge clk);
        chk("R6", {30'd0, grant_sec, grant_pri}, 32'd1);
        chk("R9", {26'd0, s_rdata}, a);
        p_addr = a[AW-1:0]; pg_valid = resident[a]; p_req = 1'b1;
        @(negedge clk);
        chk("R9", {30'd0, p_dtack, s_irq}, 32'd2);
        chk("R9", {26'd0, s_rdata}, a);
        p_req = 1'b0;
        @(negedge clk);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule